// File: doc/BRIEF.md
# Round-Robin Warp Fetch Scheduler

In a SIMT core that runs several warps, this block picks which warp fetches an instruction next. Each warp is eligible when it has at least one live thread and is not parked. A warp becomes parked when the instruction it has just fetched changes control flow or the thread mask: a conditional branch, a direct or indirect jump, a divergence split, a barrier, or a mask change. It stays parked until writeback returns that instruction and asks for the warp to be released. A rotating pointer walks the warps in order, so every eligible warp gets a turn.

The selected warp and its valid flag are registered outputs. They describe the fetch that takes place in the current cycle. A fetch proceeds only when the issue stage is not holding and no instruction-miss wait is counting down. On a fetch cycle the block also takes in two facts about the instruction being fetched: whether it parks its warp, and how many cycles its miss costs. It then decides which warp fetches in the next cycle. Instruction memory, decode and the thread-mask logic sit outside this block.

Top module: `warp_rr_sched`

## Requirements
- R1: During reset and after it, `sel_valid` is 0, `sel_id` is 0 and no warp is parked. The internal pointer starts at warp 0, so the first selection after reset is the first eligible warp counting from warp 1.
- R2: On a fetch cycle, the next selection is the first eligible warp in the order pointer+1, pointer+2, … wrapping modulo `NUM_WARPS`, with at most one full pass. It appears on `sel_id`/`sel_valid` after the clock edge, and the pointer moves to the chosen warp.
- R3: A warp is eligible only when bit w of `warp_active` is 1 and the warp is not parked.
- R4: If a pass finds no eligible warp, `sel_valid` goes to 0, `sel_id` keeps its value, and the pointer advances by one.
- R5: A fetch cycle with `sel_valid`=1 and `park_req`=1 parks warp `sel_id`. That warp is already excluded from the search made in the same cycle.
- R6: `rel_valid`=1 unparks warp `rel_id` at the end of the cycle. The search made in that same cycle still treats the warp as parked, and the warp is eligible from the next cycle on.
- R7: A cycle is a fetch cycle only when `issue_hold`=0 and the miss counter is zero. In any other cycle, `sel_id`, `sel_valid` and the pointer keep their values, and `park_req` and `miss_len` have no effect.
- R8: On a fetch cycle with `sel_valid`=1, the miss counter loads `miss_len`. On a fetch cycle with `sel_valid`=0, it loads 0. It counts down by one on every other cycle while it is nonzero, whatever the state of `issue_hold`. A load of k therefore blocks the next k cycles.
- R9: If park and release name the same warp in the same cycle, the release wins and the warp ends the cycle unparked.
- R10: `park_req` has no effect while `sel_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| warp_active | input | NUM_WARPS | Bit w is 1 when warp w has live threads |
| issue_hold | input | 1 | Issue stage is stalled; blocks fetch |
| park_req | input | 1 | The instruction fetched this cycle parks its warp |
| miss_len | input | MISS_W | Miss wait, in cycles, of the instruction fetched this cycle |
| rel_valid | input | 1 | Writeback requests the release of a warp |
| rel_id | input | IW | Warp to release |
| sel_valid | output | 1 | A warp is selected for fetch |
| sel_id | output | IW | Selected warp number |

## Verification
Every decision is registered once, so a selection, park, release or miss load driven in cycle t shows on `sel_id`/`sel_valid` one edge later. A release affects the selection only two edges later, because the search in its own cycle ignores it. A miss load of k keeps the outputs frozen for the next k edges, and the change appears on the (k+1)-th. The bench drives inputs at the falling edge and advances its behavioural model at the rising edge. It compares both outputs at every falling edge, and the directed steps sample at the exact edge counts given above.

// File: rtl/warp_rr_sched.sv
module warp_rr_sched #(
  parameter int NUM_WARPS = 8,
  parameter int MISS_W    = 4,
  localparam int IW       = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_WARPS-1:0] warp_active,
  input  logic                 issue_hold,
  input  logic                 park_req,
  input  logic [MISS_W-1:0]    miss_len,
  input  logic                 rel_valid,
  input  logic [IW-1:0]        rel_id,
  output logic                 sel_valid,
  output logic [IW-1:0]        sel_id
);

  logic [IW-1:0]        ptr_q;
  logic [NUM_WARPS-1:0] park_q;
  logic [MISS_W-1:0]    miss_q;
  logic                 fetch_en;
  logic [NUM_WARPS-1:0] park_set;
  logic [NUM_WARPS-1:0] rel_clr;
  logic [NUM_WARPS-1:0] blocked;
  logic                 found;
  logic [IW-1:0]        pick;
  logic [IW-1:0]        ptr_inc;

  assign fetch_en = !issue_hold && (miss_q == '0);
  assign park_set = (fetch_en && sel_valid && park_req) ? (NUM_WARPS'(1) << sel_id) : '0;
  assign rel_clr  = rel_valid ? (NUM_WARPS'(1) << rel_id) : '0;
  assign blocked  = park_q | park_set;
  assign ptr_inc  = IW'((int'(ptr_q) + 1) % NUM_WARPS);

  always_comb begin
    found = 1'b0;
    pick  = ptr_q;
    for (int k = 1; k <= NUM_WARPS; k++) begin
      int c;
      c = (int'(ptr_q) + k) % NUM_WARPS;
      if (!found && warp_active[c] && !blocked[c]) begin
        found = 1'b1;
        pick  = IW'(c);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q     <= '0;
      park_q    <= '0;
      miss_q    <= '0;
      sel_valid <= 1'b0;
      sel_id    <= '0;
    end else begin
      park_q <= blocked & ~rel_clr;
      if (fetch_en) begin
        sel_valid <= found;
        sel_id    <= found ? pick : sel_id;
        ptr_q     <= found ? pick : ptr_inc;
        miss_q    <= sel_valid ? miss_len : '0;
      end else if (miss_q != '0) begin
        miss_q <= miss_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/warp_rr_sched_chk.sv
module warp_rr_sched_chk #(
  parameter int NUM_WARPS = 8,
  parameter int MISS_W    = 4,
  localparam int IW       = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_WARPS-1:0] warp_active,
  input logic                 issue_hold,
  input logic                 park_req,
  input logic                 rel_valid,
  input logic [IW-1:0]        rel_id,
  input logic                 sel_valid,
  input logic [IW-1:0]        sel_id,
  input logic [NUM_WARPS-1:0] park_q,
  input logic [MISS_W-1:0]    miss_q
);

  logic                 go;
  logic [NUM_WARPS-1:0] act_d;
  logic [NUM_WARPS-1:0] park_d;

  assign go = !issue_hold && (miss_q == '0);

  always_ff @(posedge clk) begin
    act_d  <= warp_active;
    park_d <= park_q;
  end

  p_pick_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (!sel_valid || act_d[sel_id]));

  p_pick_unparked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (!sel_valid || !park_d[sel_id]));

  p_none_found_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (go && warp_active == '0) |=> !sel_valid);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> ($stable(sel_valid) && $stable(sel_id)));

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |=> !park_q[$past(rel_id)]);

  p_park_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (go && sel_valid && park_req && !(rel_valid && rel_id == sel_id)) |=> park_q[$past(sel_id)]);

  p_miss_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_q != '0) |=> (miss_q == $past(miss_q) - 1'b1));

endmodule

bind warp_rr_sched warp_rr_sched_chk #(.NUM_WARPS(NUM_WARPS), .MISS_W(MISS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .warp_active(warp_active), .issue_hold(issue_hold),
  .park_req(park_req), .rel_valid(rel_valid), .rel_id(rel_id),
  .sel_valid(sel_valid), .sel_id(sel_id), .park_q(park_q), .miss_q(miss_q)
);

// File: tb/test_warp_rr_sched.sv
module test_warp_rr_sched;
  localparam int N  = 8;
  localparam int MW = 4;
  localparam int IW = 3;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [N-1:0]  warp_active = '1;
  logic          issue_hold = 0;
  logic          park_req = 0;
  logic [MW-1:0] miss_len = 0;
  logic          rel_valid = 0;
  logic [IW-1:0] rel_id = 0;
  logic          sel_valid;
  logic [IW-1:0] sel_id;

  always #2 clk = ~clk;

  warp_rr_sched #(.NUM_WARPS(N), .MISS_W(MW)) i_warp_rr_sched (
    .clk(clk), .rst_n(rst_n), .warp_active(warp_active), .issue_hold(issue_hold),
    .park_req(park_req), .miss_len(miss_len), .rel_valid(rel_valid), .rel_id(rel_id),
    .sel_valid(sel_valid), .sel_id(sel_id)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc = 0;
  bit    done = 0;
  string cur_tag = "R1";

  int m_ptr = 0, m_sel = 0, m_miss = 0;
  bit m_val = 0;
  bit m_park [N];
  bit m_fe, m_found;
  int m_c, m_newmiss;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ptr = 0; m_sel = 0; m_val = 0; m_miss = 0;
      for (int i = 0; i < N; i++) m_park[i] = 0;
    end else begin
      m_fe = !issue_hold && (m_miss == 0);
      if (m_fe) begin
        if (m_val && park_req) m_park[m_sel] = 1;
        m_found = 0;
        for (int k = 1; k <= N; k++) begin
          m_c = (m_ptr + k) % N;
          if (!m_found && warp_active[m_c] && !m_park[m_c]) begin
            m_found = 1;
            m_sel = m_c;
          end
        end
        m_ptr = m_found ? m_sel : (m_ptr + 1) % N;
        m_newmiss = m_val ? int'(miss_len) : 0;
        m_val = m_found;
        m_miss = m_newmiss;
      end else if (m_miss > 0) begin
        m_miss = m_miss - 1;
      end
      if (rel_valid) m_park[rel_id] = 0;
    end
  end

  always @(negedge clk) begin
    cyc++;
    n_cmp++;
    if (sel_valid !== m_val || sel_id !== IW'(m_sel)) begin
      n_bad++;
      $display("FAIL %s model: got valid=%0b id=%0d, expected valid=%0b id=%0d",
               cur_tag, sel_valid, sel_id, m_val, m_sel);
    end
  end

  task automatic expect_sel(string tag, bit v, int id);
    #1;
    n_cmp++;
    if (sel_valid !== v || sel_id !== IW'(id)) begin
      n_bad++;
      $display("FAIL %s directed: got valid=%0b id=%0d, expected valid=%0b id=%0d",
               tag, sel_valid, sel_id, v, id);
    end
  endtask

  task automatic edge_then(string tag, bit v, int id);
    @(negedge clk);
    cur_tag = tag;
    expect_sel(tag, v, id);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog: got cycle %0d, expected end before 20000", cyc);
      finish_run();
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    expect_sel("R1", 0, 0);
    rst_n = 1;
    edge_then("R1", 1, 1);
    // R2: rotation with wrap
    for (int w = 2; w < N + 1; w++) edge_then("R2", 1, w % N);
    // R3: sparse mask
    warp_active = 8'b0100_1001;
    edge_then("R3", 1, 3);
    edge_then("R3", 1, 6);
    edge_then("R3", 1, 0);
    // R4: nothing eligible, pointer advances by one
    warp_active = '0;
    edge_then("R4", 0, 0);
    warp_active = 8'b0000_0001;
    edge_then("R4", 1, 0);
    // R5: park warp 0, excluded at once and afterwards
    warp_active = '1;
    park_req = 1;
    edge_then("R5", 1, 1);
    park_req = 0;
    for (int w = 2; w < N; w++) edge_then("R5", 1, w);
    edge_then("R5", 1, 1);
    // R6: release only takes effect after the decision
    warp_active = 8'b0000_0001;
    rel_valid = 1; rel_id = 0;
    edge_then("R6", 0, 1);
    rel_valid = 0;
    edge_then("R6", 1, 0);
    // R9: park and release of the same warp together
    warp_active = '1;
    park_req = 1; rel_valid = 1; rel_id = 0;
    edge_then("R9", 1, 1);
    park_req = 0; rel_valid = 0;
    warp_active = 8'b0000_0001;
    edge_then("R9", 1, 0);
    // R10: park request without a valid selection
    warp_active = '0;
    edge_then("R10", 0, 0);
    warp_active = 8'b0000_0001;
    park_req = 1;
    edge_then("R10", 1, 0);
    park_req = 0;
    warp_active = '1;
    edge_then("R10", 1, 1);
    warp_active = 8'b0000_0001;
    edge_then("R10", 1, 0);
    // R7: hold freezes outputs and ignores park_req / miss_len
    warp_active = '1;
    issue_hold = 1; park_req = 1; miss_len = 4'd9;
    for (int i = 0; i < 3; i++) edge_then("R7", 1, 0);
    issue_hold = 0; park_req = 0; miss_len = 0;
    edge_then("R7", 1, 1);
    warp_active = 8'b0000_0001;
    edge_then("R7", 1, 0);
    // R8: miss counter of 3 blocks three edges
    warp_active = '1;
    miss_len = 4'd3;
    edge_then("R8", 1, 1);
    miss_len = 0;
    for (int i = 0; i < 3; i++) edge_then("R8", 1, 1);
    edge_then("R8", 1, 2);
    // random traffic against the model
    cur_tag = "R2";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      #1;
      warp_active = ($urandom % 6 == 0) ? '0 : N'($urandom);
      issue_hold  = ($urandom % 5 == 0);
      park_req    = ($urandom % 3 == 0);
      miss_len    = ($urandom % 4 == 0) ? MW'($urandom % 4) : '0;
      rel_valid   = ($urandom % 3 == 0);
      rel_id      = IW'($urandom);
    end
    @(negedge clk);
    @(negedge clk);
    #1;
    finish_run();
  end
endmodule